// File: doc/BRIEF.md
# SPI Flash Command Frame Parser

This block sits on the device side of a SPI flash-style link. It decodes one transaction for each low period of chip select. It oversamples the serial clock, chip select and data lanes with the system clock. The first eight sampling edges always arrive on lane 0 and form the command byte. The block looks that byte up in a parameter table. Each table entry gives four attributes: the address length (3 or 4 bytes), the direction (host writes or host reads), the payload width (1, 2 or 4 lanes) and a count of dummy sampling edges.

After a known command, the address is shifted in one bit per edge on lane 0. The block then waits for the dummy edges. After that it moves payload bytes on the selected lanes until chip select rises. In write frames it emits one strobe for each received byte. In read frames it takes a byte from the `tx_byte` input each time a byte slot starts and drives that byte onto the lanes. Clock polarity and phase are set by inputs. Raising chip select ends the frame in whatever phase it has reached.

Top module: `spi_flash_frame_rx`

## Requirements
- R1: The first 8 sampling edges after chip select falls are taken from lane 0, MSB first. When the 8th edge arrives, `op_valid` pulses for one cycle with the byte on `op_code`.
- R2: Each table entry is 16 bits: [15:8] command, [7] four-byte address, [6] host write, [5:4] lane code (0=1 lane, 1=2, 2=4), [3:0] dummy edges. The default entries are 03h, 0Bh, 3Bh, 6Ch, 02h, 32h and 12h. `op_hit` tells whether the command matched an entry. A command that matches no entry produces no further strobe in that frame and drives no lane.
- R3: The address is 3 or 4 bytes, MSB first, on lane 0. After its last bit, `addr_valid` pulses once with the address zero-extended on `addr`, strictly after `op_valid`.
- R4: Payload begins only after exactly the entry's count of dummy sampling edges have followed the address.
- R5: In write frames, each sampling edge takes 1, 2 or 4 bits, MSB first. Lane 0 holds the least significant bit of each group. `rx_valid` pulses once per complete byte, with the byte on `rx_byte`.
- R6: In read frames, `tx_byte` is captured when payload starts and again after each completed byte, and each capture pulses `tx_load`. Bits go out MSB first. A single-lane read drives lane 1 (`sio_oe`=0010). A dual read drives lanes 1:0 (0011). A quad read drives lanes 3:0 (1111). Lane 0 carries the least significant bit of each group. Outputs change after a sampling edge and hold until the next one.
- R7: Data is sampled on the rising clock edge when `cpol` equals `cpha`, and otherwise on the falling edge. In modes 1 and 3 the leading edge after chip select falls is therefore never sampled.
- R8: When chip select rises, the frame ends in any phase. No strobe is issued after that and `sio_oe` returns to 0. A partial command is not reported, and the next frame starts clean.
- R9: After reset, all strobes are low and `sio_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | 0: sample on leading edge, 1: on trailing edge |
| sck | input | 1 | Serial clock from host |
| csn | input | 1 | Chip select, active low |
| sio_in | input | 4 | Data lanes as seen at the pins |
| sio_out | output | 4 | Lane values driven in read payload |
| sio_oe | output | 4 | Per-lane output enable |
| op_valid | output | 1 | Command byte received strobe |
| op_code | output | 8 | Received command byte |
| op_hit | output | 1 | Command matched a table entry |
| addr_valid | output | 1 | Address complete strobe |
| addr | output | 32 | Received address, zero-extended |
| rx_valid | output | 1 | Write payload byte strobe |
| rx_byte | output | 8 | Write payload byte |
| tx_byte | input | 8 | Next read payload byte |
| tx_load | output | 1 | `tx_byte` was captured |

## Verification
The bench uses the default parameters. The seven default table entries already cover single, dual and quad payload, 3- and 4-byte addresses, reads and writes, and zero and eight dummy edges. Every entry is exercised in mode 0. Dual-read and quad-write frames are repeated in all four clock modes. A command outside the table and frames cut short during the command, the address, the dummy edges, and write and read payload are also exercised. In read frames the host side reconstructs the bytes from the lanes. A dummy count off by even one edge shifts every byte and shows up as a data mismatch.

// File: rtl/spi_flash_frame_rx.sv
module spi_flash_frame_rx #(
  parameter int OP_COUNT = 7,
  parameter logic [OP_COUNT*16-1:0] OP_TABLE =
    {16'h12C0, 16'h3260, 16'h0240, 16'h6CA8, 16'h3B18, 16'h0B08, 16'h0300}
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpol,
  input  logic        cpha,
  input  logic        sck,
  input  logic        csn,
  input  logic [3:0]  sio_in,
  output logic [3:0]  sio_out,
  output logic [3:0]  sio_oe,
  output logic        op_valid,
  output logic [7:0]  op_code,
  output logic        op_hit,
  output logic        addr_valid,
  output logic [31:0] addr,
  output logic        rx_valid,
  output logic [7:0]  rx_byte,
  input  logic [7:0]  tx_byte,
  output logic        tx_load
);
  localparam int ENTRY_W = 16;

  typedef enum logic [2:0] {S_IDLE, S_OPC, S_ADDR, S_DUMMY, S_DATA, S_SKIP} st_t;

  st_t         st;
  logic [1:0]  sck_sy, cs_sy;
  logic        sck_d;
  logic [3:0]  sio_s1, sio_s2;
  logic [7:0]  sh, txsh;
  logic [2:0]  bitcnt;
  logic [1:0]  abyte, lc;
  logic [3:0]  dcnt;
  logic        a4, wr;
  logic [23:0] addr_sh;

  wire cs_act = !cs_sy[1];
  wire samp   = cs_act && (sck_sy[1] != sck_d) && (sck_sy[1] == (cpol == cpha));
  wire [2:0] step = (st == S_DATA) ? (3'b001 << lc) : 3'b001;
  wire [3:0] bsum = {1'b0, bitcnt} + {1'b0, step};
  wire [7:0] ser_byte = {sh[6:0], sio_s2[0]};
  wire [7:0] par_byte = (lc == 2'd0) ? ser_byte :
                        (lc == 2'd1) ? {sh[5:0], sio_s2[1:0]} : {sh[3:0], sio_s2[3:0]};

  logic       hit;
  logic [7:0] attr;
  always_comb begin
    hit  = 1'b0;
    attr = '0;
    for (int i = 0; i < OP_COUNT; i++) begin
      if (OP_TABLE[i*ENTRY_W+8 +: 8] == ser_byte) begin
        hit  = 1'b1;
        attr = OP_TABLE[i*ENTRY_W +: 8];
      end
    end
  end

  wire drive = cs_act && (st == S_DATA) && !wr;
  assign sio_out = (lc == 2'd0) ? {2'b00, txsh[7], 1'b0} :
                   (lc == 2'd1) ? {2'b00, txsh[7:6]} : txsh[7:4];
  assign sio_oe  = !drive ? 4'b0000 :
                   (lc == 2'd0) ? 4'b0010 : (lc == 2'd1) ? 4'b0011 : 4'b1111;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sy <= '0; sck_d <= 1'b0; cs_sy <= 2'b11;
      sio_s1 <= '0; sio_s2 <= '0;
    end else begin
      sck_sy <= {sck_sy[0], sck}; sck_d <= sck_sy[1];
      cs_sy  <= {cs_sy[0], csn};
      sio_s1 <= sio_in; sio_s2 <= sio_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sh <= '0; txsh <= '0; bitcnt <= '0; abyte <= '0; lc <= '0;
      dcnt <= '0; a4 <= 1'b0; wr <= 1'b0; addr_sh <= '0;
      op_valid <= 1'b0; op_code <= '0; op_hit <= 1'b0; addr_valid <= 1'b0;
      addr <= '0; rx_valid <= 1'b0; rx_byte <= '0; tx_load <= 1'b0;
    end else begin
      op_valid <= 1'b0; addr_valid <= 1'b0; rx_valid <= 1'b0; tx_load <= 1'b0;
      if (!cs_act) begin
        st <= S_IDLE;
      end else begin
        case (st)
          S_IDLE: begin
            st <= S_OPC; bitcnt <= '0; abyte <= '0; addr_sh <= '0;
          end
          S_OPC: if (samp) begin
            sh <= ser_byte; bitcnt <= bsum[2:0];
            if (bitcnt == 3'd7) begin
              op_valid <= 1'b1; op_code <= ser_byte; op_hit <= hit;
              a4 <= attr[7]; wr <= attr[6]; lc <= attr[5:4]; dcnt <= attr[3:0];
              st <= hit ? S_ADDR : S_SKIP;
            end
          end
          S_ADDR: if (samp) begin
            sh <= ser_byte; bitcnt <= bsum[2:0];
            if (bitcnt == 3'd7) begin
              addr_sh <= {addr_sh[15:0], ser_byte};
              abyte   <= abyte + 2'd1;
              if (abyte == (a4 ? 2'd3 : 2'd2)) begin
                addr_valid <= 1'b1;
                addr <= {addr_sh, ser_byte};
                if (dcnt == 4'd0) begin
                  st <= S_DATA;
                  if (!wr) begin txsh <= tx_byte; tx_load <= 1'b1; end
                end else begin
                  st <= S_DUMMY;
                end
              end
            end
          end
          S_DUMMY: if (samp) begin
            dcnt <= dcnt - 4'd1;
            if (dcnt == 4'd1) begin
              st <= S_DATA;
              if (!wr) begin txsh <= tx_byte; tx_load <= 1'b1; end
            end
          end
          S_DATA: if (samp) begin
            bitcnt <= bsum[2:0];
            if (wr) begin
              sh <= par_byte;
              if (bsum[3]) begin rx_valid <= 1'b1; rx_byte <= par_byte; end
            end else if (bsum[3]) begin
              txsh <= tx_byte; tx_load <= 1'b1;
            end else begin
              txsh <= txsh << step;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assert_single_op_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid);
  assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({op_valid, addr_valid, rx_valid}));
  assert_addr_then_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> (st == S_DUMMY || st == S_DATA));
  assert_abort_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> !(op_valid || addr_valid || rx_valid || tx_load));
  assert_oe_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (sio_oe == 4'b0000));
endmodule

// File: tb/tb_spi_flash_frame_rx.sv
module tb_spi_flash_frame_rx;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, cpol, cpha, sck, csn;
  logic [3:0]  sio_in, sio_out, sio_oe;
  logic        op_valid, op_hit, addr_valid, rx_valid, tx_load;
  logic [7:0]  op_code, rx_byte, tx_byte;
  logic [31:0] addr;

  spi_flash_frame_rx dut (
    .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .sck(sck), .csn(csn),
    .sio_in(sio_in), .sio_out(sio_out), .sio_oe(sio_oe), .op_valid(op_valid),
    .op_code(op_code), .op_hit(op_hit), .addr_valid(addr_valid), .addr(addr),
    .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_byte(tx_byte), .tx_load(tx_load));

  localparam int H = 6;
  int n_chk = 0, n_bad = 0;

  function automatic logic [7:0] tpat(int k); return 8'(8'h5A + k * 8'h3B); endfunction
  function automatic logic [7:0] wpat(int k); return 8'(8'hC3 ^ (k * 8'h29)); endfunction

  int cyc = 0, n_op = 0, n_addr = 0, n_rx = 0, n_tx = 0;
  int op_t = 0, addr_t = 0, pay_t = 0;
  bit pay_seen = 0;
  logic [7:0]  last_op, rx_log [0:63];
  logic        last_hit;
  logic [31:0] last_addr;
  always @(negedge clk) begin
    cyc++;
    if (op_valid) begin n_op++; op_t = cyc; last_op = op_code; last_hit = op_hit; end
    if (addr_valid) begin n_addr++; addr_t = cyc; last_addr = addr; pay_seen = 0; end
    if ((rx_valid || tx_load) && !pay_seen) begin pay_t = cyc; pay_seen = 1; end
    if (rx_valid) begin rx_log[n_rx % 64] = rx_byte; n_rx++; end
    if (tx_load) n_tx++;
    tx_byte = tpat(n_tx);
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  int e_cnt, e_lim;
  logic [3:0] s_dat, s_oe;
  logic [7:0] rd [0:7];
  logic [3:0] oe_first;
  int b_op, b_addr, b_rx, b_tx;

  task automatic wait_h(); repeat (H) @(negedge clk); endtask

  task automatic clk_edge(input logic [3:0] d);
    if (e_cnt >= e_lim) return;
    if (!cpha) begin
      sio_in = d; wait_h(); s_dat = sio_out; s_oe = sio_oe;
      sck = ~cpol; wait_h(); sck = cpol;
    end else begin
      sck = ~cpol; sio_in = d; wait_h(); s_dat = sio_out; s_oe = sio_oe;
      sck = cpol; wait_h();
    end
    e_cnt++;
  endtask

  task automatic set_mode(input logic p, input logic h);
    cpol = p; cpha = h; sck = p;
    repeat (10) @(negedge clk);
  endtask

  task automatic run_frame(input logic [7:0] op, input logic [31:0] adr, input int nab,
                           input int dum, input int lanes, input int nbytes, input int lim);
    b_op = n_op; b_addr = n_addr; b_rx = n_rx; b_tx = n_tx;
    e_cnt = 0; e_lim = lim; oe_first = 'x;
    csn = 1'b0; wait_h(); wait_h();
    for (int i = 0; i < 8; i++) clk_edge({3'b000, op[7-i]});
    for (int i = 0; i < nab * 8; i++) clk_edge({3'b000, adr[nab*8-1-i]});
    for (int i = 0; i < dum; i++) clk_edge(4'b0000);
    for (int b = 0; b < nbytes; b++) begin
      logic [7:0] rb = '0;
      for (int g = 0; g < 8 / lanes; g++) begin
        int gi = (int'(wpat(b)) >> (8 - lanes * (g + 1))) & ((1 << lanes) - 1);
        int v;
        clk_edge(4'(gi));
        if (b == 0 && g == 0) oe_first = s_oe;
        v = (lanes == 1) ? int'(s_dat[1]) : (int'(s_dat) & ((1 << lanes) - 1));
        rb = 8'((int'(rb) << lanes) | v);
      end
      rd[b] = rb;
    end
    wait_h(); csn = 1'b1; sio_in = '0;
    repeat (12) @(negedge clk);
  endtask

  task automatic check_frame(input string tag, input logic [7:0] op, input bit hit,
                             input int w_op, input int w_addr, input logic [31:0] adr,
                             input int nab, input bit wr, input int lanes,
                             input int w_pay, input int full);
    chk(n_op - b_op == w_op, "R1", {tag, " op count"}, n_op - b_op, w_op);
    if (w_op > 0) begin
      chk(last_op == op, "R1", {tag, " op code"}, last_op, op);
      chk(last_hit == hit, "R2", {tag, " op hit"}, last_hit, hit);
    end
    chk(n_addr - b_addr == w_addr, "R3", {tag, " addr count"}, n_addr - b_addr, w_addr);
    if (w_addr > 0) begin
      logic [31:0] ea = (nab == 3) ? (adr & 32'h00FF_FFFF) : adr;
      chk(last_addr == ea, "R3", {tag, " addr value"}, last_addr, ea);
      chk(op_t < addr_t, "R3", {tag, " addr after op"}, addr_t, op_t + 1);
    end
    chk(n_rx - b_rx == (wr ? w_pay : 0), "R5", {tag, " rx count"}, n_rx - b_rx, wr ? w_pay : 0);
    chk(n_tx - b_tx == (wr ? 0 : w_pay), "R6", {tag, " tx loads"}, n_tx - b_tx, wr ? 0 : w_pay);
    if (wr) begin
      for (int i = 0; i < full; i++)
        chk(rx_log[(b_rx + i) % 64] == wpat(i), "R5", {tag, " rx byte"}, rx_log[(b_rx + i) % 64], wpat(i));
    end else if (w_pay > 0) begin
      logic [3:0] em = (lanes == 1) ? 4'b0010 : (lanes == 2) ? 4'b0011 : 4'b1111;
      chk(oe_first == em, "R6", {tag, " lane enables"}, oe_first, em);
      for (int i = 0; i < full; i++)
        chk(rd[i] == tpat(b_tx + i), "R4", {tag, " read byte after dummy"}, rd[i], tpat(b_tx + i));
    end
    if (w_pay > 0 && w_addr > 0)
      chk(pay_t >= addr_t, "R4", {tag, " payload after addr"}, pay_t, addr_t);
    chk(sio_oe == 4'b0000, "R8", {tag, " lanes released"}, sio_oe, 0);
  endtask

  task automatic t_reset();
    chk(!op_valid && !addr_valid && !rx_valid && !tx_load, "R9", "strobes after reset",
        {op_valid, addr_valid, rx_valid, tx_load}, 0);
    chk(sio_oe == 4'b0000, "R9", "oe after reset", sio_oe, 0);
  endtask

  task automatic t_table_sweep();
    set_mode(1'b0, 1'b0);
    run_frame(8'h03, 32'h0012_3456, 3, 0, 1, 3, 1000);
    check_frame("R6 read1", 8'h03, 1, 1, 1, 32'h0012_3456, 3, 0, 1, 4, 3);
    run_frame(8'h0B, 32'h00AB_CDEF, 3, 8, 1, 3, 1000);
    check_frame("R4 read1 dummy", 8'h0B, 1, 1, 1, 32'h00AB_CDEF, 3, 0, 1, 4, 3);
    run_frame(8'h3B, 32'h0001_0203, 3, 8, 2, 3, 1000);
    check_frame("R6 read2", 8'h3B, 1, 1, 1, 32'h0001_0203, 3, 0, 2, 4, 3);
    run_frame(8'h6C, 32'hDEAD_BEEF, 4, 8, 4, 3, 1000);
    check_frame("R6 read4 addr4", 8'h6C, 1, 1, 1, 32'hDEAD_BEEF, 4, 0, 4, 4, 3);
    run_frame(8'h02, 32'h0077_8899, 3, 0, 1, 3, 1000);
    check_frame("R5 write1", 8'h02, 1, 1, 1, 32'h0077_8899, 3, 1, 1, 3, 3);
    run_frame(8'h32, 32'h0044_5566, 3, 0, 4, 3, 1000);
    check_frame("R5 write4", 8'h32, 1, 1, 1, 32'h0044_5566, 3, 1, 4, 3, 3);
    run_frame(8'h12, 32'h8765_4321, 4, 0, 1, 2, 1000);
    check_frame("R3 write addr4", 8'h12, 1, 1, 1, 32'h8765_4321, 4, 1, 1, 2, 2);
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++) begin
      set_mode(m[1], m[0]);
      run_frame(8'h3B, 32'h0010_2030 + m, 3, 8, 2, 2, 1000);
      check_frame("R7 mode read2", 8'h3B, 1, 1, 1, 32'h0010_2030 + m, 3, 0, 2, 3, 2);
      run_frame(8'h32, 32'h0050_6070 + m, 3, 0, 4, 2, 1000);
      check_frame("R7 mode write4", 8'h32, 1, 1, 1, 32'h0050_6070 + m, 3, 1, 4, 2, 2);
    end
    set_mode(1'b0, 1'b0);
  endtask

  task automatic t_unknown();
    run_frame(8'h9F, 32'h0011_2233, 3, 0, 1, 2, 1000);
    check_frame("R2 unknown op", 8'h9F, 0, 1, 0, 0, 3, 1, 1, 0, 0);
    chk(n_tx - b_tx == 0, "R2", "unknown op no tx", n_tx - b_tx, 0);
  endtask

  task automatic t_aborts();
    run_frame(8'h03, 32'h0012_3456, 3, 0, 1, 2, 5);
    check_frame("R8 abort in op", 8'h03, 1, 0, 0, 0, 3, 0, 1, 0, 0);
    run_frame(8'h02, 32'h0012_3456, 3, 0, 1, 2, 18);
    check_frame("R8 abort in addr", 8'h02, 1, 1, 0, 0, 3, 1, 1, 0, 0);
    run_frame(8'h0B, 32'h0034_5678, 3, 8, 1, 2, 35);
    check_frame("R8 abort in dummy", 8'h0B, 1, 1, 1, 32'h0034_5678, 3, 0, 1, 0, 0);
    run_frame(8'h02, 32'h0034_5678, 3, 0, 1, 3, 43);
    check_frame("R8 abort in write data", 8'h02, 1, 1, 1, 32'h0034_5678, 3, 1, 1, 1, 1);
    run_frame(8'h6C, 32'h0102_0304, 4, 8, 4, 3, 51);
    check_frame("R8 abort in read data", 8'h6C, 1, 1, 1, 32'h0102_0304, 4, 0, 4, 2, 1);
    run_frame(8'h3B, 32'h00CA_FE00, 3, 8, 2, 2, 1000);
    check_frame("R8 clean restart", 8'h3B, 1, 1, 1, 32'h00CA_FE00, 3, 0, 2, 3, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpol = 1'b0; cpha = 1'b0; sck = 1'b0; csn = 1'b1; sio_in = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_table_sweep();
    t_modes();
    t_unknown();
    t_aborts();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule